// File: doc/BRIEF.md
# Dual-Channel Angle Readout Latch

This block sits between two angle tracking channels and a shared 14-bit readout bus. Each channel delivers binary angle words with an update strobe, and the block keeps the most recent word of each channel in its own output latch. A channel-select input chooses which latch is read. An active-low output enable starts a read, and the bus is driven only while that enable is low. The bus is presented as a data word plus a drive-enable, and the tri-state net is resolved one level up.

While a channel is being read, its latch is frozen so the word cannot change mid-read. Updates that arrive for that channel during the window go into a one-deep pending register, where the newest one wins. The pending word is copied into the latch on the first clock edge after the window closes. The other channel keeps taking updates as normal. A data-valid flag rises a parameterised number of clock edges after the read starts, and it starts that count again whenever the select input moves during a read.

Top module: `dual_angle_latch`

## Requirements
- R1: After reset both latches read as zero, no held update is pending, and valid_o is low.
- R2: drive_en_o is high exactly while oe_ni is low. With oe_ni high the resolved bus is high impedance on all 14 lines.
- R3: data_o carries the channel A latch when sel_i is 0 and the channel B latch when sel_i is 1. Bit 13 is the MSB with a weight of 180 degrees, and each lower bit has half the weight of the bit above it.
- R4: On a channel that is not being read, a strobe loads its word at that clock edge, so it is visible in the next cycle.
- R5: While oe_ni is low, strobes for the selected channel leave its latch unchanged, and data_o stays stable.
- R6: A strobe that is held off during a read is stored as pending, and a later held strobe replaces it. The pending word loads at the first edge after the read window of that channel ends (oe_ni high or the select moved away). A new strobe at that same edge takes precedence over the pending word.
- R7: During a read of one channel, the other channel keeps loading its strobes.
- R8: valid_o goes high after SETTLE_CYC rising edges during which oe_ni is low and sel_i is unchanged. It is low whenever oe_ni is high.
- R9: A change of sel_i while oe_ni is low drops valid_o in the same cycle and restarts the count, with the first edge that sees the new select counting as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_a_i | input | 1 | Channel A update strobe |
| angle_a_i | input | ANGLE_W | Channel A angle word |
| upd_b_i | input | 1 | Channel B update strobe |
| angle_b_i | input | ANGLE_W | Channel B angle word |
| sel_i | input | 1 | Channel select: 0 selects A, 1 selects B |
| oe_ni | input | 1 | Output enable, active low |
| data_o | output | ANGLE_W | Selected angle word |
| drive_en_o | output | 1 | Bus drive enable |
| valid_o | output | 1 | Read data has settled |

## Verification
Directed sequences cover four cases. The first is a quiet read after reset. The second is a read of A with several held strobes, which separates "newest pending wins" from "first pending wins" and from "no freeze". The third moves the select mid-read, which tests both the release of the pending word and the restart of valid. The fourth is a strobe that arrives on the same edge that ends the window. Seeded random traffic then toggles the enable and select and fires independent strobes on both channels at high rates. Every cycle is compared with a bench model, so held, released and pass-through updates all occur at every distance from the window edges.

// File: rtl/angle_latch_pkg.sv
package angle_latch_pkg;
  localparam int ANGLE_W_DEF = 14;
  localparam int SETTLE_DEF  = 4;
  localparam int N_CH        = 2;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;
endpackage

// File: rtl/angle_chan_hold.sv
module angle_chan_hold #(
  parameter int ANGLE_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               freeze_i,
  input  logic               upd_i,
  input  logic [ANGLE_W-1:0] word_i,
  output logic [ANGLE_W-1:0] word_o
);
  logic [ANGLE_W-1:0] lat_q, pend_q;
  logic               pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (freeze_i) begin
      if (upd_i) begin
        pend_q   <= word_i;
        pend_v_q <= 1'b1;
      end
    end else if (upd_i) begin
      // fresh word beats a stale pending one
      lat_q    <= word_i;
      pend_v_q <= 1'b0;
    end else if (pend_v_q) begin
      lat_q    <= pend_q;
      pend_v_q <= 1'b0;
    end
  end

  assign word_o = lat_q;
endmodule

// File: rtl/angle_settle_timer.sv
module angle_settle_timer #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_ni,
  input  logic sel_i,
  output logic valid_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYC);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             sel_q;
  logic             sel_moved;

  assign sel_moved = (sel_i != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel_i;
      if (oe_ni)               cnt_q <= '0;
      else if (sel_moved)      cnt_q <= ONE;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + ONE;
    end
  end

  assign valid_o = !oe_ni && !sel_moved && (cnt_q == LIMIT);
endmodule

// File: rtl/dual_angle_latch.sv
module dual_angle_latch
  import angle_latch_pkg::*;
#(
  parameter int ANGLE_W    = ANGLE_W_DEF,
  parameter int SETTLE_CYC = SETTLE_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_a_i,
  input  logic [ANGLE_W-1:0] angle_a_i,
  input  logic               upd_b_i,
  input  logic [ANGLE_W-1:0] angle_b_i,
  input  logic               sel_i,
  input  logic               oe_ni,
  output logic [ANGLE_W-1:0] data_o,
  output logic               drive_en_o,
  output logic               valid_o
);
  logic [ANGLE_W-1:0] word_in  [N_CH];
  logic [ANGLE_W-1:0] word_lat [N_CH];
  logic               upd      [N_CH];
  chan_e              sel_ch;

  assign sel_ch     = chan_e'(sel_i);
  assign word_in[0] = angle_a_i;
  assign word_in[1] = angle_b_i;
  assign upd[0]     = upd_a_i;
  assign upd[1]     = upd_b_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic frz;
    assign frz = !oe_ni && (sel_ch == chan_e'(c));
    angle_chan_hold #(.ANGLE_W(ANGLE_W)) u_hold (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .freeze_i (frz),
      .upd_i    (upd[c]),
      .word_i   (word_in[c]),
      .word_o   (word_lat[c])
    );
  end

  angle_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .oe_ni   (oe_ni),
    .sel_i   (sel_i),
    .valid_o (valid_o)
  );

  assign data_o     = (sel_ch == CH_B) ? word_lat[1] : word_lat[0];
  assign drive_en_o = !oe_ni;
endmodule

// File: rtl/dual_angle_latch_chk.sv
module dual_angle_latch_chk #(
  parameter int ANGLE_W = 14
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sel_i,
  input logic               oe_ni,
  input logic [ANGLE_W-1:0] data_o,
  input logic               drive_en_o,
  input logic               valid_o
);
  a_r2_no_drive_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_en_o);
  a_r2_drive_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni |-> drive_en_o);
  a_r5_read_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni && $past(!oe_ni) && (sel_i == $past(sel_i))) |-> $stable(data_o));
  a_r8_valid_needs_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !valid_o);
  a_r8_rise_settled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> ($past(!oe_ni) && (sel_i == $past(sel_i))));
  a_r9_sel_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni && (sel_i != $past(sel_i))) |-> !valid_o);
endmodule

bind dual_angle_latch dual_angle_latch_chk #(.ANGLE_W(ANGLE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .oe_ni      (oe_ni),
  .data_o     (data_o),
  .drive_en_o (drive_en_o),
  .valid_o    (valid_o)
);

// File: tb/dual_angle_latch_bench.sv
`timescale 1ns/1ps
module dual_angle_latch_bench;
  localparam int W  = 14;
  localparam int SC = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         upd_a = 1'b0, upd_b = 1'b0, sel = 1'b0, oe_n = 1'b1;
  logic [W-1:0] ang_a = '0, ang_b = '0;
  logic [W-1:0] data;
  logic         drv, vld;
  wire  [W-1:0] bus;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model
  logic [W-1:0] m_lat [2];
  logic [W-1:0] m_pend[2];
  bit           m_pv  [2];
  int           m_cnt;
  bit           m_selq;

  always #5 clk = ~clk;

  assign bus = drv ? data : 'z;

  dual_angle_latch #(.ANGLE_W(W), .SETTLE_CYC(SC)) u_dual_angle_latch (
    .clk_i(clk), .rst_ni(rst_n),
    .upd_a_i(upd_a), .angle_a_i(ang_a),
    .upd_b_i(upd_b), .angle_b_i(ang_b),
    .sel_i(sel), .oe_ni(oe_n),
    .data_o(data), .drive_en_o(drv), .valid_o(vld)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_valid(bit oe_n_v, bit s);
    return !oe_n_v && (s == m_selq) && (m_cnt == SC);
  endfunction

  task automatic model_edge(bit oe_n_v, bit s, bit ua, logic [W-1:0] wa, bit ub, logic [W-1:0] wb);
    bit u[2];
    logic [W-1:0] w[2];
    u[0] = ua; u[1] = ub; w[0] = wa; w[1] = wb;
    for (int c = 0; c < 2; c++) begin
      if (!oe_n_v && (s == c[0])) begin
        if (u[c]) begin m_pend[c] = w[c]; m_pv[c] = 1; end
      end else if (u[c]) begin
        m_lat[c] = w[c]; m_pv[c] = 0;
      end else if (m_pv[c]) begin
        m_lat[c] = m_pend[c]; m_pv[c] = 0;
      end
    end
    if (oe_n_v)           m_cnt = 0;
    else if (s != m_selq) m_cnt = 1;
    else if (m_cnt != SC) m_cnt++;
    m_selq = s;
  endtask

  // called at negedge: apply, check, take edge
  task automatic cyc(bit oe_n_v, bit s, bit ua, logic [W-1:0] wa,
                     bit ub, logic [W-1:0] wb, string tag);
    oe_n = oe_n_v; sel = s; upd_a = ua; ang_a = wa; upd_b = ub; ang_b = wb;
    #1;
    chk("R2 drive", {{(W-1){1'b0}}, drv}, {{(W-1){1'b0}}, !oe_n_v});
    if (oe_n_v) chk("R2 hi-z", bus, {W{1'bz}});
    else        chk(tag, bus, m_lat[s]);
    chk((!oe_n_v && s != m_selq) ? "R9 valid" : "R8 valid",
        {{(W-1){1'b0}}, vld}, {{(W-1){1'b0}}, exp_valid(oe_n_v, s)});
    @(posedge clk);
    model_edge(oe_n_v, s, ua, wa, ub, wb);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    for (int c = 0; c < 2; c++) begin m_lat[c] = '0; m_pend[c] = '0; m_pv[c] = 0; end
    m_cnt = 0; m_selq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state on both channels
    chk("R1 valid", {{(W-1){1'b0}}, vld}, '0);
    cyc(0, 0, 0, '0, 0, '0, "R1 chan A zero");
    cyc(0, 1, 0, '0, 0, '0, "R1 chan B zero");
    cyc(1, 0, 0, '0, 0, '0, "R2");

    // R4: unread update visible next cycle; R3 MSB = 180 deg
    cyc(1, 0, 1, 14'h2000, 0, '0, "R4");
    cyc(0, 0, 0, '0, 0, '0, "R3 msb weight");
    chk("R3 msb 180deg", {{(W-1){1'b0}}, bus[W-1]}, 14'd1);
    cyc(1, 0, 1, 14'h1234, 0, '0, "R4");
    cyc(0, 0, 0, '0, 0, '0, "R4 loaded");

    // R5/R7: read A, held strobes on A, B keeps loading
    cyc(0, 0, 1, 14'h0AAA, 1, 14'h3333, "R5");
    cyc(0, 0, 1, 14'h0555, 0, '0, "R5");
    for (int i = 0; i < SC + 2; i++) cyc(0, 0, 0, '0, 0, '0, "R5 hold");
    chk("R5 frozen A", bus, 14'h1234);
    // R6/R7: move select to B ends A window; B shows loaded word
    cyc(0, 1, 0, '0, 0, '0, "R7 chan B during A read");
    cyc(1, 0, 0, '0, 0, '0, "R2");
    cyc(0, 0, 0, '0, 0, '0, "R6 pending newest applied");
    chk("R6 pending A", bus, 14'h0555);

    // R6: strobe at the closing edge beats the pending word
    cyc(0, 0, 1, 14'h0111, 0, '0, "R5");
    cyc(1, 0, 1, 14'h0222, 0, '0, "R6");
    cyc(0, 0, 0, '0, 0, '0, "R6 fresh wins");
    chk("R6 fresh A", bus, 14'h0222);

    // R9: select toggling mid-read restarts valid
    for (int i = 0; i < SC + 1; i++) cyc(0, 0, 0, '0, 0, '0, "R8");
    cyc(0, 1, 0, '0, 0, '0, "R9");
    for (int i = 0; i < SC + 1; i++) cyc(0, 1, 0, '0, 0, '0, "R9 recount");
    cyc(1, 1, 0, '0, 0, '0, "R8");

    // seeded random traffic
    begin
      bit o = 1, s = 0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(0, 9) == 0) o = ~o;
        if ($urandom_range(0, 14) == 0) s = ~s;
        cyc(o, s, $urandom_range(0, 1) == 1, W'($urandom),
            $urandom_range(0, 2) == 0, W'($urandom), "R3 random");
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule